// File: doc/BRIEF.md
# Latched-Read 64-bit Timebase Counter

This block is a free-running 64-bit up-counter that serves as a continuous timebase for a processor subsystem. Software reaches it through a small register window on a single-cycle register bus: an address, a write strobe and write data, with read data returned combinationally from the address in the same cycle. A separate clock-enable input, `cnt_tick`, paces the count.

A bus of 32-bit words cannot read a 64-bit count atomically. To get around this, a command write to the control register copies all 64 bits into a pair of snapshot words in one cycle, and software then reads those words at leisure. A second command encoding of the same register moves a start value, staged beforehand in two 32-bit preload words, into the counter. A divider field sets how many ticks make one count step. Bit 0 of the control register also enables counting.

Top module: `snapcnt_timebase`

## Requirements
- R1: After reset the counter, the snapshot words, the preload words and the control register all read as zero.
- R2: The preload words (low at 0x74, high at 0x78) are plain read/write storage. Writing them leaves the count unchanged until a commit command is written.
- R3: A control write (0x68) with bit 0 = 1 and bit 1 = 0 copies the count into the snapshot words (low at 0x7C, high at 0x80). The value copied is the count as it stood in the cycle of the write, before any step taken on that same clock edge.
- R4: A control write with bit 0 = 1 and bit 1 = 1 loads the 64-bit preload value into the counter. The loaded value is exact even when a count step falls in the same cycle. A control write with bit 1 set and bit 0 clear loads nothing.
- R5: Control bit 0 is the run enable. With the divider at zero, the counter steps by one on each cycle in which run is set and `cnt_tick` is high. It holds its value in every other cycle, and a carry from the low word passes into the high word.
- R6: Control bits [7:4] hold a divider value D, and the counter steps once per D+1 qualifying ticks. A load commit restarts the tick count, so the first step after a commit comes on the (D+1)-th tick.
- R7: The counter wraps from all ones to zero with no other effect.
- R8: The snapshot words change only on a snapshot command. Reading them has no side effect, and a control write with bit 0 clear leaves them unchanged.
- R9: The live count reads at 0x6C (low) and 0x70 (high). Any unmapped offset reads as zero. Writes to the live-count and snapshot offsets are ignored.
- R10: Reading the control register returns run in bit 0 and the divider in bits [7:4]. All other bits, including the command bit 1, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | 1 | Count enable pulse, one per count opportunity |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data for `bus_addr`, same cycle |

## Verification
The assertions assume that a write lasts exactly one cycle and that the address is stable whenever a read is sampled. They also assume that a control command is a single write, so that a snapshot and a load cannot meet in the same cycle. The stimulus follows all of this: each bus write is a one-cycle strobe driven between clock edges, and the bench keeps `cnt_tick` low during every read except where a test deliberately places a tick in the same cycle as a command. That arrangement fixes the expected count for each readback to an exact value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Register byte offsets; software decodes these, so they are fixed.
   localparam logic [7:0] OFS_CTRL   = 8'h68;
   localparam logic [7:0] OFS_LIVELO = 8'h6C;
   localparam logic [7:0] OFS_LIVEHI = 8'h70;
   localparam logic [7:0] OFS_PRELO  = 8'h74;
   localparam logic [7:0] OFS_PREHI  = 8'h78;
   localparam logic [7:0] OFS_SNAPLO = 8'h7C;
   localparam logic [7:0] OFS_SNAPHI = 8'h80;

   // Control field positions
   localparam int unsigned CTL_RUN_BIT  = 0;
   localparam int unsigned CTL_LOAD_BIT = 1;
   localparam int unsigned CTL_DIV_LSB  = 4;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_SNAP = 2'd1,
      CMD_LOAD = 2'd2
   } tmr_cmd_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned DIV_W   = 4,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             adv
);
   generate
      if (HAS_DIV) begin : g_div
         logic [DIV_W-1:0] pre_q;
         logic             expire;

         assign expire = (pre_q >= div);
         assign adv    = run && tick && expire;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (restart) begin
               pre_q <= '0;
            end else if (run && tick) begin
               pre_q <= expire ? '0 : pre_q + 1'b1;
            end
         end

         // R6: no step while the divider is nonzero and the tick count was just restarted
         a_r6_restart_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (restart && div != '0) |=> !adv);
      end else begin : g_nodiv
         assign adv = run && tick;
      end
   endgenerate
endmodule

// File: rtl/tmr_count64.sv
module tmr_count64
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  tmr_cmd_e         cmd,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] snap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cmd == CMD_LOAD) begin
         cnt_q <= load_val;          // load wins over a step
      end else if (adv) begin
         cnt_q <= cnt_q + 1'b1;      // silent wrap
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (cmd == CMD_SNAP) begin
         snap_q <= cnt_q;
      end
   end

   // R4: a commit places the preload value exactly
   a_r4_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_LOAD) |=> cnt_q == $past(load_val));
   // R3: snapshot holds the pre-edge count
   a_r3_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_SNAP) |=> snap_q == $past(cnt_q));
   // R8: snapshot words move only on a snapshot command
   a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_SNAP) |=> $stable(snap_q));
   // R5 / R7: a step adds one modulo 2^CNT_W
   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cmd != CMD_LOAD) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R5: no step, no load, no change
   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && cmd != CMD_LOAD) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned DIV_W   = 4,
   parameter bit          HAS_DIV = 1'b1,
   localparam int unsigned CNT_W  = 2 * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  snap,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              run_en,
   output logic [DIV_W-1:0]  div_val,
   output logic [CNT_W-1:0]  load_val,
   output tmr_cmd_e          cmd
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_LIVELO = ADDR_W'(OFS_LIVELO);
   localparam logic [ADDR_W-1:0] A_LIVEHI = ADDR_W'(OFS_LIVEHI);
   localparam logic [ADDR_W-1:0] A_PRELO  = ADDR_W'(OFS_PRELO);
   localparam logic [ADDR_W-1:0] A_PREHI  = ADDR_W'(OFS_PREHI);
   localparam logic [ADDR_W-1:0] A_SNAPLO = ADDR_W'(OFS_SNAPLO);
   localparam logic [ADDR_W-1:0] A_SNAPHI = ADDR_W'(OFS_SNAPHI);

   logic ctrl_wr;
   assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

   always_comb begin
      cmd = CMD_NONE;
      if (ctrl_wr && bus_wdata[CTL_RUN_BIT]) begin
         cmd = bus_wdata[CTL_LOAD_BIT] ? CMD_LOAD : CMD_SNAP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_en  <= 1'b0;
         div_val <= '0;
      end else if (ctrl_wr) begin
         run_en  <= bus_wdata[CTL_RUN_BIT];
         div_val <= HAS_DIV ? bus_wdata[CTL_DIV_LSB +: DIV_W] : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_val <= '0;
      end else if (bus_we) begin
         if (bus_addr == A_PRELO) load_val[BUS_W-1:0]     <= bus_wdata;
         if (bus_addr == A_PREHI) load_val[CNT_W-1:BUS_W] <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CTRL: begin
            bus_rdata[CTL_RUN_BIT]            = run_en;
            bus_rdata[CTL_DIV_LSB +: DIV_W]   = div_val;
         end
         A_LIVELO: bus_rdata = cnt[BUS_W-1:0];
         A_LIVEHI: bus_rdata = cnt[CNT_W-1:BUS_W];
         A_PRELO:  bus_rdata = load_val[BUS_W-1:0];
         A_PREHI:  bus_rdata = load_val[CNT_W-1:BUS_W];
         A_SNAPLO: bus_rdata = snap[BUS_W-1:0];
         A_SNAPHI: bus_rdata = snap[CNT_W-1:BUS_W];
         default:  bus_rdata = '0;
      endcase
   end

   // R10: a control write sets run from bit 0
   a_r10_run_from_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> run_en == $past(bus_wdata[CTL_RUN_BIT]));
   // R2: preload words change only on a bus write
   a_r2_preload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(load_val));
endmodule

// File: rtl/snapcnt_timebase.sv
module snapcnt_timebase
   import tmr_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned BUS_W   = 32,
   parameter int unsigned DIV_W   = 4,
   parameter bit          HAS_DIV = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   localparam int unsigned CNT_W = 2 * BUS_W;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("snapcnt_timebase: ADDR_W must reach offset 0x80");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("snapcnt_timebase: BUS_W too narrow for the control fields");
      end
      if (DIV_W < 1 || DIV_W + CTL_DIV_LSB > BUS_W) begin : g_bad_div
         $error("snapcnt_timebase: divider field does not fit the control word");
      end
   endgenerate

   logic             run_en;
   logic [DIV_W-1:0] div_val;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] snap_q;
   logic             adv;
   tmr_cmd_e         cmd;

   tmr_regs #(
      .ADDR_W (ADDR_W),
      .BUS_W  (BUS_W),
      .DIV_W  (DIV_W),
      .HAS_DIV(HAS_DIV)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .cnt      (cnt_q),
      .snap     (snap_q),
      .bus_rdata(bus_rdata),
      .run_en   (run_en),
      .div_val  (div_val),
      .load_val (load_val),
      .cmd      (cmd)
   );

   tmr_prescale #(
      .DIV_W  (DIV_W),
      .HAS_DIV(HAS_DIV)
   ) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (cnt_tick),
      .run    (run_en),
      .div    (div_val),
      .restart(cmd == CMD_LOAD),
      .adv    (adv)
   );

   tmr_count64 #(
      .CNT_W(CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (adv),
      .cmd     (cmd),
      .load_val(load_val),
      .cnt_q   (cnt_q),
      .snap_q  (snap_q)
   );

   // R5: a step needs both the tick and the run enable
   a_r5_step_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> (cnt_tick && run_en));
endmodule

// File: tb/tb_snapcnt_timebase.sv
module tb_snapcnt_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   bit rd_strobe = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0]  addr;
      logic [31:0] exp;
      string       tag;
   } exp_t;
   exp_t exp_q[$];

   always #4 clk = ~clk;   // 125 MHz

   snapcnt_timebase dut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   // Monitor: compare each read against the next expected item
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rd_strobe) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
               errors++;
               $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                        it.tag, it.addr, bus_rdata, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit tk = 1'b0);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1; cnt_tick = tk;
      @(negedge clk);
      bus_we = 1'b0; cnt_tick = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      bus_addr = a;
      it.addr = a; it.exp = e; it.tag = tag;
      exp_q.push_back(it);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic rd64(input logic [7:0] a_lo, input logic [63:0] e, input string tag);
      rd(a_lo, e[31:0], tag);
      rd(a_lo + 8'h04, e[63:32], tag);
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      cnt_tick = 1'b1;
      repeat (n) @(negedge clk);
      cnt_tick = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(8'h68, 32'h0, "R1 ctrl");
      rd64(8'h6C, 64'h0, "R1 live");
      rd64(8'h74, 64'h0, "R1 preload");
      rd64(8'h7C, 64'h0, "R1 snapshot");

      // R2 preload is storage only
      wr(8'h74, 32'hFFFF_FFF0);
      wr(8'h78, 32'h0000_0001);
      rd64(8'h74, 64'h1_FFFF_FFF0, "R2 preload readback");
      rd64(8'h6C, 64'h0, "R2 count untouched");

      // R4 commit, R10 readback
      wr(8'h68, 32'h3);
      rd64(8'h6C, 64'h1_FFFF_FFF0, "R4 commit");
      rd(8'h68, 32'h1, "R10 ctrl run only");

      // R5 stepping with carry into high word
      ticks(20);
      rd64(8'h6C, 64'h2_0000_0004, "R5 twenty ticks");
      repeat (5) @(negedge clk);
      rd64(8'h6C, 64'h2_0000_0004, "R5 no tick no step");

      // R3 snapshot takes pre-edge value while a step lands
      wr(8'h68, 32'h1, 1'b1);
      rd64(8'h7C, 64'h2_0000_0004, "R3 snapshot value");
      rd64(8'h6C, 64'h2_0000_0005, "R3 step beside snapshot");

      // R8 snapshot holds, reads are side-effect free
      ticks(10);
      rd64(8'h7C, 64'h2_0000_0004, "R8 hold after ticks");
      rd64(8'h7C, 64'h2_0000_0004, "R8 reread");
      rd64(8'h6C, 64'h2_0000_000F, "R5 live after ticks");

      // R5 stop, R8 no snapshot with bit0 clear
      wr(8'h68, 32'h0);
      ticks(5);
      rd64(8'h6C, 64'h2_0000_000F, "R5 stopped");
      rd64(8'h7C, 64'h2_0000_0004, "R8 bit0 clear no snap");

      // R4 bit1 alone loads nothing
      wr(8'h68, 32'h2);
      rd64(8'h6C, 64'h2_0000_000F, "R4 bit1 alone");
      rd(8'h68, 32'h0, "R10 bit1 reads zero");

      // R9 read-only offsets ignore writes, unmapped reads zero
      wr(8'h6C, 32'h1234_5678);
      wr(8'h70, 32'h1234_5678);
      wr(8'h80, 32'hDEAD_BEEF);
      rd64(8'h6C, 64'h2_0000_000F, "R9 live write ignored");
      rd64(8'h7C, 64'h2_0000_0004, "R9 snapshot write ignored");
      rd(8'h00, 32'h0, "R9 unmapped 0x00");
      rd(8'h84, 32'h0, "R9 unmapped 0x84");

      // R4 load wins over a simultaneous step
      wr(8'h74, 32'hAAAA_0000);
      wr(8'h78, 32'h0000_5555);
      wr(8'h68, 32'h1);
      wr(8'h68, 32'h3, 1'b1);
      rd64(8'h6C, 64'h5555_AAAA_0000, "R4 load beats step");

      // R6 divider 3: one step per four ticks
      wr(8'h68, 32'h33);
      rd(8'h68, 32'h31, "R10 ctrl with divider");
      ticks(3);
      rd64(8'h6C, 64'h5555_AAAA_0000, "R6 three ticks no step");
      ticks(1);
      rd64(8'h6C, 64'h5555_AAAA_0001, "R6 fourth tick steps");
      ticks(8);
      rd64(8'h6C, 64'h5555_AAAA_0003, "R6 eight more ticks");

      // R7 wrap
      wr(8'h74, 32'hFFFF_FFFE);
      wr(8'h78, 32'hFFFF_FFFF);
      wr(8'h68, 32'h3);
      ticks(3);
      rd64(8'h6C, 64'h0000_0000_0000_0001, "R7 wrap");
      wr(8'h68, 32'h1);
      rd64(8'h7C, 64'h1, "R7 snapshot after wrap");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule